// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines. It masks them with a per-line enable and routes each line to one of two processor request outputs, a normal request and a fast request. Sixteen programmable slots each pair a source number with a 32-bit handler address. The handler software reads one register and receives the address of the handler to run, so it never has to scan a status word for the highest pending line.

Slots are ordered: slot 0 is the most urgent. When a normal-request line is pending and enabled, the vector register returns the address of the lowest-numbered enabled slot that serves a pending line. If no enabled slot serves any pending line, the vector register returns a programmable fallback address. The first vector read that finds a pending request freezes the returned address. Any write to the vector register releases it, and that write acts as the acknowledge at the end of the handler.

The register bus is a plain single-cycle port with address, write strobe, read strobe and write data. Read data appears on the clock edge that samples the read strobe. The read strobe is needed because a vector read has a side effect.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the enable word, the routing word and every slot control word read as zero, and both request outputs are low.
- R2: A write to offset 0x010 sets every enable bit where the data has a one. A write to offset 0x014 clears every enable bit where the data has a one. Zero bits leave the enable unchanged. Offset 0x010 reads back the enable word, and offset 0x014 reads as zero.
- R3: The normal-request status at offset 0x000 equals the source lines ANDed with the enables and with the inverted routing bits. `irq_o` is high exactly when that status is nonzero.
- R4: A routing bit of 1 at offset 0x00C sends its line to `fiq_o` and to the fast status at offset 0x004, and removes it from the normal status. A routing bit of 0 selects the normal request.
- R5: Slot n keeps its handler address at offset 0x100+4n and its control word at offset 0x200+4n. In the control word, bit 5 enables the slot and bits 4:0 name the source it serves. A read of offset 0x030 returns the address of the lowest-numbered enabled slot whose source is set in the normal status.
- R6: Offset 0x034 holds the fallback address. A vector read returns it when no enabled slot serves a pending normal-status line, including when nothing is pending. A read that finds nothing pending does not freeze the vector.
- R7: A vector read made while the normal status is nonzero freezes the returned address. Later vector reads return that same address whatever the source lines do, until the acknowledge.
- R8: Any write to offset 0x030 acknowledges the interrupt. The next vector read reflects the current pending lines.
- R9: Offset 0x008 returns the raw source lines, whatever the enables are.
- R10: Read data updates on the clock edge that samples `rd_i` and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt lines |
| addr_i | input | 12 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two events can fall in the same cycle. The first is a change on the source lines during a vector read. The bench raises a more urgent line while a vector is frozen and then drops every line, and it expects the frozen address each time. The second is the acknowledge write during the edge on which a new line appears. The bench drives both at the same clock edge and expects the next vector read to return the new line's slot address, which shows that the release did not miss the arrival.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_SRC_N  = 32;
  localparam int VIC_SLOT_N = 16;
  localparam int VIC_AW     = 12;
  localparam int VIC_DW     = 32;

  localparam logic [VIC_AW-1:0] OFS_IRQ_STAT  = 12'h000;
  localparam logic [VIC_AW-1:0] OFS_FIQ_STAT  = 12'h004;
  localparam logic [VIC_AW-1:0] OFS_RAW       = 12'h008;
  localparam logic [VIC_AW-1:0] OFS_ROUTE     = 12'h00C;
  localparam logic [VIC_AW-1:0] OFS_EN_SET    = 12'h010;
  localparam logic [VIC_AW-1:0] OFS_EN_CLR    = 12'h014;
  localparam logic [VIC_AW-1:0] OFS_VEC       = 12'h030;
  localparam logic [VIC_AW-1:0] OFS_DFLT      = 12'h034;
  localparam int                SLOT_ADDR_BASE = 'h100;
  localparam int                SLOT_CTRL_BASE = 'h200;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = VIC_SRC_N,
  parameter int NUM_SLOT = VIC_SLOT_N,
  parameter int AW       = VIC_AW,
  parameter int DW       = VIC_DW,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] route_o,
  output logic [DW-1:0]      dflt_o,
  output logic [DW-1:0]      slot_addr_o [NUM_SLOT],
  output logic               slot_en_o   [NUM_SLOT],
  output logic [SRC_W-1:0]   slot_src_o  [NUM_SLOT]
);
  logic wr_set, wr_clr;
  assign wr_set = wr_i && (addr_i == OFS_EN_SET);
  assign wr_clr = wr_i && (addr_i == OFS_EN_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      route_o <= '0;
      dflt_o  <= '0;
    end else begin
      if (wr_set)      en_o <= en_o | wdata_i[NUM_SRC-1:0];
      else if (wr_clr) en_o <= en_o & ~wdata_i[NUM_SRC-1:0];
      if (wr_i && addr_i == OFS_ROUTE) route_o <= wdata_i[NUM_SRC-1:0];
      if (wr_i && addr_i == OFS_DFLT)  dflt_o  <= wdata_i;
    end
  end

  for (genvar n = 0; n < NUM_SLOT; n++) begin : g_slot
    localparam logic [AW-1:0] A_OFS = AW'(SLOT_ADDR_BASE + 4*n);
    localparam logic [AW-1:0] C_OFS = AW'(SLOT_CTRL_BASE + 4*n);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_addr_o[n] <= '0;
        slot_en_o[n]   <= 1'b0;
        slot_src_o[n]  <= '0;
      end else begin
        if (wr_i && addr_i == A_OFS) slot_addr_o[n] <= wdata_i;
        if (wr_i && addr_i == C_OFS) begin
          slot_en_o[n]  <= wdata_i[SRC_W];
          slot_src_o[n] <= wdata_i[SRC_W-1:0];
        end
      end
    end
  end

  // R2: set and clear take effect on the next edge
  a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_o & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));
  a_r2_clr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_o & $past(wdata_i[NUM_SRC-1:0])) == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = VIC_SRC_N,
  parameter int NUM_SLOT = VIC_SLOT_N,
  parameter int DW       = VIC_DW,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_stat_i,
  input  logic [DW-1:0]      slot_addr_i [NUM_SLOT],
  input  logic               slot_en_i   [NUM_SLOT],
  input  logic [SRC_W-1:0]   slot_src_i  [NUM_SLOT],
  input  logic [DW-1:0]      dflt_i,
  output logic [DW-1:0]      vec_o
);
  logic [NUM_SLOT-1:0] hit, grant;

  for (genvar n = 0; n < NUM_SLOT; n++) begin : g_hit
    assign hit[n] = slot_en_i[n] && irq_stat_i[slot_src_i[n]];
  end

  // lowest slot index wins
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    vec_o = dflt_i;
    for (int n = 0; n < NUM_SLOT; n++) begin
      if (hit[n] && !found) begin
        found    = 1'b1;
        grant[n] = 1'b1;
        vec_o    = slot_addr_i[n];
      end
    end
  end

  a_r5_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r5_grant_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant != '0) |-> (irq_stat_i != '0));
endmodule

// File: rtl/vic_lock.sv
module vic_lock
  import vic_pkg::*;
#(
  parameter int DW = VIC_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_vec_i,
  input  logic          ack_i,
  input  logic          any_irq_i,
  input  logic [DW-1:0] cur_vec_i,
  output logic [DW-1:0] vec_o
);
  logic          locked_q;
  logic [DW-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      held_q   <= '0;
    end else if (ack_i) begin
      locked_q <= 1'b0;
    end else if (rd_vec_i && !locked_q && any_irq_i) begin
      locked_q <= 1'b1;
      held_q   <= cur_vec_i;
    end
  end

  assign vec_o = locked_q ? held_q : cur_vec_i;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !ack_i) |=> (locked_q && $stable(held_q)));
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !locked_q);
  a_r6_no_lock_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && !any_irq_i) |=> !locked_q);
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = VIC_SRC_N,
  parameter int NUM_SLOT = VIC_SLOT_N,
  parameter int AW       = VIC_AW,
  parameter int DW       = VIC_DW,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0] en, route, irq_stat, fiq_stat;
  logic [DW-1:0]      dflt, cur_vec, vec;
  logic [DW-1:0]      slot_addr [NUM_SLOT];
  logic               slot_en   [NUM_SLOT];
  logic [SRC_W-1:0]   slot_src  [NUM_SLOT];
  logic [DW-1:0]      rd_mux;

  vic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .en_o(en), .route_o(route), .dflt_o(dflt),
    .slot_addr_o(slot_addr), .slot_en_o(slot_en), .slot_src_o(slot_src)
  );

  assign irq_stat = src_i & en & ~route;
  assign fiq_stat = src_i & en & route;
  assign irq_o    = |irq_stat;
  assign fiq_o    = |fiq_stat;

  vic_prio #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DW(DW)) u_prio (
    .clk_i, .rst_ni, .irq_stat_i(irq_stat),
    .slot_addr_i(slot_addr), .slot_en_i(slot_en), .slot_src_i(slot_src),
    .dflt_i(dflt), .vec_o(cur_vec)
  );

  vic_lock #(.DW(DW)) u_lock (
    .clk_i, .rst_ni,
    .rd_vec_i (rd_i && addr_i == OFS_VEC),
    .ack_i    (wr_i && addr_i == OFS_VEC),
    .any_irq_i(irq_o),
    .cur_vec_i(cur_vec),
    .vec_o    (vec)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_IRQ_STAT: rd_mux = DW'(irq_stat);
      OFS_FIQ_STAT: rd_mux = DW'(fiq_stat);
      OFS_RAW:      rd_mux = DW'(src_i);
      OFS_ROUTE:    rd_mux = DW'(route);
      OFS_EN_SET:   rd_mux = DW'(en);
      OFS_VEC:      rd_mux = vec;
      OFS_DFLT:     rd_mux = dflt;
      default:      rd_mux = '0;
    endcase
    for (int n = 0; n < NUM_SLOT; n++) begin
      if (addr_i == AW'(SLOT_ADDR_BASE + 4*n)) rd_mux = slot_addr[n];
      if (addr_i == AW'(SLOT_CTRL_BASE + 4*n)) rd_mux = DW'({slot_en[n], slot_src[n]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  a_r3_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> (!irq_o && !fiq_o));
  a_r10_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic        rd_d = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  vic_ctrl u_vic_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  always @(posedge clk) rd_d <= rd;

  // monitor: compare read data one edge after the read strobe
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk);
    src = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R1 irq_o low");
    chk({31'b0, fiq}, 32'h0, "R1 fiq_o low");
    bus_rd(12'h010, 32'h0, "R1 enables zero");
    bus_rd(12'h00C, 32'h0, "R1 routing zero");
    bus_rd(12'h200, 32'h0, "R1 slot0 ctrl zero");

    bus_wr(12'h010, 32'h0000_00FF);
    bus_rd(12'h010, 32'h0000_00FF, "R2 set");
    bus_wr(12'h010, 32'h0000_0100);
    bus_wr(12'h014, 32'h0000_000F);
    bus_rd(12'h010, 32'h0000_01F0, "R2 set then clear");
    bus_wr(12'h014, 32'h0);
    bus_rd(12'h010, 32'h0000_01F0, "R2 zero clear no effect");
    bus_rd(12'h014, 32'h0, "R2 clear reads zero");

    set_src(32'h0000_0011);
    bus_rd(12'h008, 32'h0000_0011, "R9 raw lines");
    bus_rd(12'h000, 32'h0000_0010, "R3 masked status");
    chk({31'b0, irq}, 32'h1, "R3 irq_o high");

    bus_wr(12'h00C, 32'h0000_0010);
    @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R4 irq_o off when routed fast");
    chk({31'b0, fiq}, 32'h1, "R4 fiq_o high");
    bus_rd(12'h004, 32'h0000_0010, "R4 fast status");
    bus_rd(12'h000, 32'h0, "R4 normal status empty");
    bus_wr(12'h00C, 32'h0);

    bus_wr(12'h100, 32'hA000_0000); bus_wr(12'h200, 32'h27);
    bus_wr(12'h104, 32'hB000_0000); bus_wr(12'h204, 32'h24);
    bus_wr(12'h108, 32'hC000_0000); bus_wr(12'h208, 32'h05);
    bus_wr(12'h034, 32'hDEAD_0000);
    bus_rd(12'h204, 32'h24, "R5 slot ctrl readback");
    bus_rd(12'h104, 32'hB000_0000, "R5 slot addr readback");

    set_src(32'h0000_0010);
    bus_rd(12'h030, 32'hB000_0000, "R5 slot1 vector");
    bus_wr(12'h030, 32'h0);
    set_src(32'h0000_0090);
    bus_rd(12'h030, 32'hA000_0000, "R5 slot0 outranks slot1");
    bus_wr(12'h030, 32'h0);
    set_src(32'h0000_0020);
    bus_rd(12'h030, 32'hDEAD_0000, "R6 disabled slot falls back");
    bus_wr(12'h030, 32'h0);

    set_src(32'h0000_0010);
    bus_rd(12'h030, 32'hB000_0000, "R7 first read");
    set_src(32'h0000_0090);
    bus_rd(12'h030, 32'hB000_0000, "R7 frozen vs urgent line");
    set_src(32'h0);
    bus_rd(12'h030, 32'hB000_0000, "R7 frozen after lines drop");
    bus_wr(12'h030, 32'h0);
    set_src(32'h0000_0080);
    bus_rd(12'h030, 32'hA000_0000, "R8 released after ack");
    bus_wr(12'h030, 32'h0);

    bus_wr(12'h014, 32'h0000_0080);
    @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R3 cleared line silent");
    bus_rd(12'h030, 32'hDEAD_0000, "R6 nothing pending gives fallback");
    set_src(32'h0000_0010);
    bus_rd(12'h030, 32'hB000_0000, "R6 idle read did not freeze");

    // ack lands on the same edge as a new line
    bus_wr(12'h010, 32'h0000_0080);
    @(negedge clk);
    addr = 12'h030; wdata = 32'h0; wr = 1'b1; src = 32'h0000_0090;
    @(negedge clk);
    wr = 1'b0;
    bus_rd(12'h030, 32'hA000_0000, "R8 ack same edge as new line");
    bus_wr(12'h030, 32'h0);

    repeat (3) @(negedge clk);
    chk(rdata, 32'hA000_0000, "R10 rdata holds while idle");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule